// File: doc/BRIEF.md
# Time-Multiplexed Programmable FIR Filter

This block is a single-channel FIR filter built on a fixed bank of sixteen multiply-accumulate units. Each unit can be reused 1, 2, 4 or 8 times per sample period, so the filter runs 16, 32, 64 or 128 taps. The longer the filter, the lower the input sample rate. A decimate option doubles the tap count again and produces one result for every second input sample. Signed 16-bit samples enter on a strobed input. Signed 32-bit results leave on a bus that has a registered output enable.

For a longer filter made of several stages, each stage passes its input samples on, delayed by its own length, to the next stage. It also adds a 32-bit partial sum from another stage into every result. Coefficients are signed 16-bit values. They are loaded through an address/data/write-enable port while no result is being computed.

Top module: `tmux_fir`

## Requirements
- R1: `mode_i[3]` enables the filter. `mode_i[2:1]` holds a reuse code c in 0..3, and each unit then serves 2^c taps per sample period. `mode_i[0]` = 1 asks for decimation, which doubles the length. The tap count is 16·2^(c+d), where d is the decimate bit. With c = 3 the decimate bit is ignored, so code 1111 behaves exactly like 1110.
- R2: A result equals the expansion input plus the sum of coef[t]·x[n−t] for t from 0 to taps−1, wrapped to 32 bits. Here x[n] is the newest accepted sample, and samples older than the last reset count as zero. Coefficient address t weights tap t. Addresses at or above the tap count have no effect.
- R3: Without decimation, every accepted sample yields exactly one result. With decimation, only the 1st, 3rd, 5th and so on accepted sample after reset yields one. Samples may arrive every 2^c cycles with no result lost.
- R4: `res_valid_o` pulses for one cycle and `result_o` takes the new value on the (L+2)-th rising edge after the edge that captured the sample, where L = taps/16.
- R5: While `mode_i[3]` = 0, sample strobes are ignored. No result appears and `dly_data_o` stays unchanged.
- R6: A coefficient write is stored only when no result computation is in progress. The computation for a sample is in progress on the L edges that follow the edge that captured it. A write offered during that window is dropped.
- R7: After a sample x[n] is accepted, `dly_data_o` holds x[n−taps], or 0 if that sample does not exist.
- R8: `res_drv_o` equals the value `oe_i` had at the previous rising edge. `result_o` shows the result register when `res_drv_o` is 1 and is high-impedance otherwise.
- R9: Reset clears the delay line, the coefficients, the accumulators, the result, `res_valid_o`, `res_drv_o` and `dly_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Enable, reuse code and decimate bit |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 16 | Signed input sample |
| casc_i | input | 32 | Partial sum from another stage |
| oe_i | input | 1 | Output enable, registered |
| cw_en_i | input | 1 | Coefficient write strobe |
| cw_addr_i | input | 7 | Coefficient address (tap index) |
| cw_data_i | input | 16 | Signed coefficient |
| res_valid_o | output | 1 | Result strobe |
| result_o | output | 32 | Signed result, tristated |
| res_drv_o | output | 1 | Registered driver enable of result_o |
| dly_data_o | output | 16 | Input sample delayed by the tap count |

## Verification
The bench runs every mode at its highest legal input rate. It predicts each result from a sample history, and it loads nonzero coefficients above the active tap count. A design that mis-maps taps to units, uses the wrong length, or reads a stale delay-line entry in the middle of a decimating frame gives wrong sums. A wrong pipeline depth or a lost back-to-back frame shows up as a result outside its due cycle. The bench also offers a coefficient write in the middle of a frame and then checks that the next result still uses the old coefficient. It checks that the decimate bit is ignored at the longest reuse code, that the output enable lags by one edge, and that the delayed sample output tracks the length.

// File: rtl/tmux_fir_pkg.sv
package tmux_fir_pkg;
  localparam int DATA_W_D   = 16;
  localparam int RES_W_D    = 32;
  localparam int N_MAC_D    = 16;
  localparam int MAX_RLOG_D = 3;

  typedef struct packed {
    logic v;
    logic first;
    logic last;
  } iss_t;

  // log2 of uses per unit per output frame
  function automatic logic [1:0] mode_llog(input logic [3:0] m);
    logic dec;
    dec = m[0] & ~(&m[2:1]);
    return m[2:1] + {1'b0, dec};
  endfunction

  function automatic logic mode_dec(input logic [3:0] m);
    return m[0] & ~(&m[2:1]);
  endfunction
endpackage

// File: rtl/tmux_fir_ctrl.sv
module tmux_fir_ctrl
  import tmux_fir_pkg::*;
#(
  parameter int PH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      mode_i,
  input  logic            smp_valid_i,
  output logic            accept_o,
  output logic            busy_o,
  output logic [1:0]      llog_o,
  output logic [PH_W-1:0] phase_o,
  output logic            shift_o,
  output iss_t            iss_o,
  output logic            acc_v_o,
  output logic            acc_first_o,
  output logic            done_o
);
  logic            dec;
  logic [PH_W-1:0] last_ph;
  logic            start;
  logic            active_q, odd_q, shift_q;
  logic [PH_W-1:0] phase_q;
  logic            pv_q, pfirst_q, plast_q, done_q;

  assign dec      = mode_dec(mode_i);
  assign llog_o   = mode_llog(mode_i);
  assign last_ph  = PH_W'((1 << llog_o) - 1);
  assign accept_o = smp_valid_i & mode_i[3];
  assign start    = accept_o & (~dec | ~odd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      odd_q    <= 1'b0;
      shift_q  <= 1'b0;
      phase_q  <= '0;
    end else begin
      if (accept_o) odd_q <= dec ? ~odd_q : 1'b0;
      if (start) begin
        active_q <= 1'b1;
        phase_q  <= '0;
        shift_q  <= 1'b0;
      end else if (active_q) begin
        if (phase_q == last_ph) active_q <= 1'b0;
        phase_q <= phase_q + 1'b1;
        // second sample of a decimating frame moved the line by one
        if (accept_o) shift_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q     <= 1'b0;
      pfirst_q <= 1'b0;
      plast_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      pv_q     <= iss_o.v;
      pfirst_q <= iss_o.v & iss_o.first;
      plast_q  <= iss_o.v & iss_o.last;
      done_q   <= pv_q & plast_q;
    end
  end

  assign busy_o      = active_q;
  assign phase_o     = phase_q;
  assign shift_o     = shift_q;
  assign iss_o.v     = active_q;
  assign iss_o.first = (phase_q == '0);
  assign iss_o.last  = (phase_q == last_ph);
  assign acc_v_o     = pv_q;
  assign acc_first_o = pfirst_q;
  assign done_o      = done_q;
endmodule

// File: rtl/tmux_fir_coef.sv
module tmux_fir_coef #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  parameter int NRD   = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          busy_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [DW-1:0] rdata_o [NRD]
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && !busy_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/tmux_fir_delay.sv
module tmux_fir_delay #(
  parameter int DW    = 16,
  parameter int DEPTH = 129
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] line_o [DEPTH]
);
  logic [DW-1:0] line_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
    end else if (shift_i) begin
      line_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/tmux_fir_mac.sv
module tmux_fir_mac #(
  parameter int DW = 16,
  parameter int RW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] coef_i,
  input  logic [DW-1:0] data_i,
  input  logic          iss_v_i,
  input  logic          acc_v_i,
  input  logic          acc_first_i,
  output logic [RW-1:0] acc_o
);
  logic signed [RW-1:0] c_ext, d_ext, prod_q, acc_q;

  assign c_ext = {{(RW-DW){coef_i[DW-1]}}, coef_i};
  assign d_ext = {{(RW-DW){data_i[DW-1]}}, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      if (iss_v_i) prod_q <= c_ext * d_ext;
      if (acc_v_i) acc_q <= acc_first_i ? prod_q : acc_q + prod_q;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/tmux_fir.sv
module tmux_fir
  import tmux_fir_pkg::*;
#(
  parameter int DATA_W   = DATA_W_D,
  parameter int RES_W    = RES_W_D,
  parameter int N_MAC    = N_MAC_D,
  parameter int MAX_RLOG = MAX_RLOG_D
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [3:0]                          mode_i,
  input  logic                                smp_valid_i,
  input  logic [DATA_W-1:0]                   smp_data_i,
  input  logic [RES_W-1:0]                    casc_i,
  input  logic                                oe_i,
  input  logic                                cw_en_i,
  input  logic [$clog2(N_MAC<<MAX_RLOG)-1:0]  cw_addr_i,
  input  logic [DATA_W-1:0]                   cw_data_i,
  output logic                                res_valid_o,
  output logic [RES_W-1:0]                    result_o,
  output logic                                res_drv_o,
  output logic [DATA_W-1:0]                   dly_data_o
);
  localparam int MAX_TAPS = N_MAC << MAX_RLOG;
  localparam int CA_W     = $clog2(MAX_TAPS);
  localparam int DL_D     = MAX_TAPS + 1;
  localparam int DL_AW    = $clog2(DL_D);
  localparam int PH_W     = MAX_RLOG;

  logic              accept, busy, shift, acc_v, acc_first, done;
  logic [1:0]        llog;
  logic [PH_W-1:0]   phase;
  iss_t              iss;
  logic [CA_W-1:0]   caddr [N_MAC];
  logic [DATA_W-1:0] cdata [N_MAC];
  logic [DL_AW-1:0]  didx  [N_MAC];
  logic [DATA_W-1:0] dline [DL_D];
  logic [RES_W-1:0]  acc   [N_MAC];
  logic [RES_W-1:0]  sum;
  logic [DL_AW-1:0]  dly_idx;
  logic [RES_W-1:0]  res_q;
  logic              res_v_q, drv_q;
  logic [DATA_W-1:0] dly_q;

  tmux_fir_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .smp_valid_i (smp_valid_i),
    .accept_o    (accept),
    .busy_o      (busy),
    .llog_o      (llog),
    .phase_o     (phase),
    .shift_o     (shift),
    .iss_o       (iss),
    .acc_v_o     (acc_v),
    .acc_first_o (acc_first),
    .done_o      (done)
  );

  tmux_fir_delay #(.DW(DATA_W), .DEPTH(DL_D)) u_dline (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (accept),
    .din_i   (smp_data_i),
    .line_o  (dline)
  );

  tmux_fir_coef #(.DW(DATA_W), .DEPTH(MAX_TAPS), .NRD(N_MAC)) u_coef (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cw_en_i),
    .busy_i  (busy),
    .waddr_i (cw_addr_i),
    .wdata_i (cw_data_i),
    .raddr_i (caddr),
    .rdata_o (cdata)
  );

  // unit m serves taps m*L .. m*L+L-1, one per phase
  for (genvar m = 0; m < N_MAC; m++) begin : g_mac
    assign caddr[m] = (CA_W'(m) << llog) | CA_W'(phase);
    assign didx[m]  = DL_AW'(caddr[m]) + DL_AW'(shift);

    tmux_fir_mac #(.DW(DATA_W), .RW(RES_W)) u_mac (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .coef_i      (cdata[m]),
      .data_i      (dline[didx[m]]),
      .iss_v_i     (iss.v),
      .acc_v_i     (acc_v),
      .acc_first_i (acc_first),
      .acc_o       (acc[m])
    );
  end

  always_comb begin
    sum = casc_i;
    for (int m = 0; m < N_MAC; m++) sum = sum + acc[m];
  end

  assign dly_idx = DL_AW'((N_MAC << llog) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      res_v_q <= 1'b0;
      drv_q   <= 1'b0;
      dly_q   <= '0;
    end else begin
      drv_q   <= oe_i;
      res_v_q <= done;
      if (done)   res_q <= sum;
      if (accept) dly_q <= dline[dly_idx];
    end
  end

  assign res_valid_o = res_v_q;
  assign res_drv_o   = drv_q;
  assign result_o    = drv_q ? res_q : 'z;
  assign dly_data_o  = dly_q;
endmodule

// File: rtl/tmux_fir_chk.sv
module tmux_fir_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  mode_i,
  input logic        oe_i,
  input logic        res_valid_o,
  input logic        res_drv_o,
  input logic [15:0] dly_data_o
);
  // R8
  oe_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (res_drv_o == $past(oe_i)));

  // R5
  idle_dly_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[3] |=> $stable(dly_data_o));

  // R3
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && (mode_i[2:0] != 3'b000)) |=> !res_valid_o);

  // R9
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!res_valid_o && !res_drv_o && dly_data_o == '0));
endmodule

bind tmux_fir tmux_fir_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .oe_i        (oe_i),
  .res_valid_o (res_valid_o),
  .res_drv_o   (res_drv_o),
  .dly_data_o  (dly_data_o)
);

// File: tb/tb_tmux_fir.sv
module tb_tmux_fir;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  mode_i = 4'b0;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_data_i = '0;
  logic [31:0] casc_i = '0;
  logic        oe_i = 1'b1;
  logic        cw_en_i = 1'b0;
  logic [6:0]  cw_addr_i = '0;
  logic [15:0] cw_data_i = '0;
  logic        res_valid_o, res_drv_o;
  wire  [31:0] result_o;
  logic [15:0] dly_data_o;

  int checks = 0;
  int errs = 0;
  int coef_m [128];
  int xs [1024];
  int nx = 0;
  int dly_m = 0;
  bit odd = 1'b0;

  always #10 clk_i = ~clk_i;

  tmux_fir dut (
    .clk_i, .rst_ni, .mode_i, .smp_valid_i, .smp_data_i, .casc_i, .oe_i,
    .cw_en_i, .cw_addr_i, .cw_data_i, .res_valid_o, .result_o, .res_drv_o,
    .dly_data_o
  );

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] m);
    @(negedge clk_i);
    rst_ni = 1'b0; mode_i = m; smp_valid_i = 1'b0; cw_en_i = 1'b0;
    casc_i = '0; oe_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    nx = 0; odd = 1'b0; dly_m = 0;
    for (int t = 0; t < 128; t++) coef_m[t] = 0;
  endtask

  task automatic load_coefs(input int seed);
    for (int t = 0; t < 128; t++) begin
      int v;
      @(negedge clk_i);
      v = ((t * 37 + seed * 11) % 201) - 100;
      cw_en_i = 1'b1; cw_addr_i = 7'(t); cw_data_i = 16'(v);
      coef_m[t] = v;
    end
    @(negedge clk_i);
    cw_en_i = 1'b0;
  endtask

  task automatic run_stream(input int nsmp, input int sp, input int kind, input int seed,
                            input int wr_at, input int wr_addr, input int wr_val,
                            input bit wr_take, input string tag);
    int rl, ll, lcnt, taps, total;
    bit de, en, dchk;
    int eq [$];
    int dq [$];
    rl    = int'(mode_i[2:1]);
    de    = mode_i[0] && (rl != 3);
    en    = mode_i[3];
    ll    = rl + int'(de);
    lcnt  = 1 << ll;
    taps  = 16 << ll;
    total = nsmp * sp + lcnt + 8;
    dchk  = 1'b0;
    for (int j = 0; j < total; j++) begin
      @(negedge clk_i);
      if (dchk) begin
        chk($signed(dly_data_o) == dly_m, en ? {tag, " R7 delayed data"} : {tag, " R5 delayed data held"},
            int'($signed(dly_data_o)), dly_m);
        dchk = 1'b0;
      end
      if (res_valid_o) begin
        if (dq.size() > 0 && dq[0] == j) begin
          chk($signed(result_o) == eq[0], {tag, " R2 R1 result value"}, int'($signed(result_o)), eq[0]);
          void'(eq.pop_front()); void'(dq.pop_front());
        end else begin
          chk(1'b0, {tag, " R3 R5 unexpected result strobe"}, 1, 0);
        end
      end else if (dq.size() > 0 && dq[0] == j) begin
        chk(1'b0, {tag, " R4 result missing at due cycle"}, 0, 1);
        void'(eq.pop_front()); void'(dq.pop_front());
      end
      smp_valid_i = 1'b0;
      cw_en_i = 1'b0;
      if (j == wr_at) begin
        cw_en_i = 1'b1; cw_addr_i = 7'(wr_addr); cw_data_i = 16'(wr_val);
        if (wr_take) coef_m[wr_addr] = wr_val;
      end
      if ((j % sp) == 0 && (j / sp) < nsmp) begin
        int v;
        int i;
        i = j / sp;
        v = (kind == 1) ? ((i == 0) ? 1000 : 0) : (((i * 73 + seed * 29) % 4001) - 2000);
        smp_valid_i = 1'b1; smp_data_i = 16'(v);
        if (en) begin
          xs[nx] = v; nx++;
          if (!de || !odd) begin
            int s;
            s = int'(casc_i);
            for (int t = 0; t < taps; t++)
              if (nx - 1 - t >= 0) s = s + coef_m[t] * xs[nx-1-t];
            eq.push_back(s);
            dq.push_back(j + lcnt + 3);
          end
          if (de) odd = !odd;
          dly_m = (nx - 1 - taps >= 0) ? xs[nx-1-taps] : 0;
        end
        dchk = 1'b1;
      end
    end
    smp_valid_i = 1'b0;
    cw_en_i = 1'b0;
    chk(dq.size() == 0, {tag, " R3 all results delivered"}, dq.size(), 0);
  endtask

  task automatic t_reset;
    do_reset(4'b1000);
    chk(res_valid_o == 1'b0, "R9 valid clear", int'(res_valid_o), 0);
    chk(res_drv_o == 1'b0, "R9 driver enable clear", int'(res_drv_o), 0);
    chk(dly_data_o == 16'h0, "R9 delayed data clear", int'(dly_data_o), 0);
    // coefficients cleared: all results zero
    run_stream(20, 1, 0, 3, -1, 0, 0, 1'b0, "reset coefs");
  endtask

  task automatic t_mode(input logic [3:0] m, input int nsmp, input int kind, input int casc,
                        input string tag);
    int sp;
    do_reset(m);
    load_coefs(int'(m) + 5);
    casc_i = 32'(casc);
    sp = 1 << int'(m[2:1]);
    run_stream(nsmp, sp, kind, int'(m), -1, 0, 0, 1'b0, tag);
  endtask

  task automatic t_disabled;
    do_reset(4'b0010);
    load_coefs(9);
    run_stream(6, 2, 0, 9, -1, 0, 0, 1'b0, "disabled R5");
  endtask

  task automatic t_busy_write;
    do_reset(4'b1110);
    load_coefs(13);
    // write lands mid-frame and must be dropped
    run_stream(2, 16, 0, 13, 3, 0, 3000, 1'b0, "busy write R6");
    // write while idle is stored and used at once
    run_stream(2, 16, 0, 14, 0, 0, 3000, 1'b1, "idle write R6");
  endtask

  task automatic t_oe;
    @(negedge clk_i);
    oe_i = 1'b0;
    #1 chk(res_drv_o == 1'b1, "R8 enable not yet taken", int'(res_drv_o), 1);
    @(negedge clk_i);
    chk(res_drv_o == 1'b0, "R8 enable dropped after edge", int'(res_drv_o), 0);
    oe_i = 1'b1;
    #1 chk(res_drv_o == 1'b0, "R8 enable held before edge", int'(res_drv_o), 0);
    @(negedge clk_i);
    chk(res_drv_o == 1'b1, "R8 enable restored", int'(res_drv_o), 1);
  endtask

  initial begin
    t_reset();
    t_mode(4'b1000, 40, 0, 0,     "mode 000 R1");
    t_mode(4'b1000, 20, 1, 12345, "impulse cascade R2");
    t_mode(4'b1001, 70, 0, -77,   "mode 001 R1");
    t_mode(4'b1010, 50, 0, 0,     "mode 010 R1");
    t_mode(4'b1011, 80, 0, 500,   "mode 011 R1");
    t_mode(4'b1100, 80, 0, 0,     "mode 100 R1");
    t_mode(4'b1101, 150, 0, 0,    "mode 101 R1");
    t_mode(4'b1110, 150, 0, 0,    "mode 110 R1");
    t_mode(4'b1111, 40, 0, 0,     "mode 111 same as 110 R1");
    t_oe();
    t_disabled();
    t_busy_write();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule